// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block guards a system against software that stops running. Once enabled, it steps through four timeout stages in a fixed order. Each stage has its own timeout and its own escalation action. Software keeps the system alive by strobing the feed input before a stage runs out. A feed puts the timer back at the start of the first stage and fires nothing.

When a stage runs out, its action takes effect and the next stage starts from a count of zero. The last stage wraps back to the first. An action can do nothing, raise a held interrupt, or send out a reset pulse on one of these outputs:

- a CPU reset line;
- a system reset line;
- on the always-on-domain variant only, the system reset line together with an always-on reset line.

Pulse widths come from a 3-bit duration code. The code is converted to clock cycles from the clock-frequency parameter.

Top module: `wdog_stager`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `irq_o`, `cpu_rst_o`, `sys_rst_o` and `aon_rst_o` are all low, and the timer is at stage 0 with a count of zero.
- R2: A stage with limit L expires on its L-th consecutive enabled, unfed rising edge after it was entered. A limit of 0 behaves as 1. On expiry the next stage starts from zero, and stage 3 is followed by stage 0.
- R3: An enabled edge with `feed` high clears the count, returns the timer to stage 0 and fires no action, even on the edge where the stage would have expired.
- R4: The action of stage k is read from `stage_act_i[3k+2:3k]`, and its limit from `stage_limit_i[CNT_W*k +: CNT_W]`. Codes 0, 5, 6 and 7 have no effect, but the stage still expires and advances.
- R5: Code 1 sets `irq_o` from the expiring edge onward. It stays high until an edge with `irq_clr` high and no new code-1 expiry; a new expiry wins over a clear on the same edge.
- R6: Code 2 drives `cpu_rst_o` high for exactly the number of cycles selected by `cpu_len_i`, starting at the expiring edge.
- R7: Code 3 drives `sys_rst_o` high for the number of cycles selected by `sys_len_i` and leaves `aon_rst_o` low.
- R8: With `AON_DOMAIN`=1, code 4 drives both `sys_rst_o` and `aon_rst_o` for the `sys_len_i` width. With `AON_DOMAIN`=0, code 4 has no effect and `aon_rst_o` never rises.
- R9: Length codes 0 to 7 stand for 100, 200, 300, 400, 500, 800, 1600 and 3200 ns. Each becomes ceil(ns*CLK_HZ/1e9) cycles, with a minimum of 1. A new firing while a pulse is running reloads the full width.
- R10: An edge with `en` low clears the count and stage and drops `irq_o`, and no action fires. A reset pulse already running still completes its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timer enable |
| feed | input | 1 | Feed strobe that restarts stage 0 |
| irq_clr | input | 1 | Clears the held interrupt |
| stage_limit_i | input | 4*CNT_W | Per-stage timeout limits, stage k at bits CNT_W*k |
| stage_act_i | input | 12 | Per-stage 3-bit action codes, stage k at bits 3k |
| cpu_len_i | input | 3 | CPU reset pulse length code |
| sys_len_i | input | 3 | System reset pulse length code |
| irq_o | output | 1 | Held interrupt |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |
| aon_rst_o | output | 1 | Always-on domain reset pulse |

## Verification
Every output is a register, so an expiry, a feed or an enable change sampled at rising edge n shows at the outputs just after edge n. The bench drives its inputs at falling edges and keeps a model that it advances at each rising edge from the rules above. It compares all outputs of both variants at the next falling edge, half a cycle after the edge that should have changed them. Pulse widths are also counted in whole cycles against a width table that the bench computes itself.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int NSTAGE = 4;
  localparam int ACT_W  = 3;
  localparam int LEN_W  = 3;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE = 3'd0,
    ACT_IRQ  = 3'd1,
    ACT_CPU  = 3'd2,
    ACT_SYS  = 3'd3,
    ACT_AON  = 3'd4
  } wd_act_e;

  // Nominal duration of a pulse length code, in nanoseconds.
  function automatic int unsigned len_ns(input logic [LEN_W-1:0] code);
    case (code)
      3'd0:    return 100;
      3'd1:    return 200;
      3'd2:    return 300;
      3'd3:    return 400;
      3'd4:    return 500;
      3'd5:    return 800;
      3'd6:    return 1600;
      default: return 3200;
    endcase
  endfunction

  // Cycles = ceil(ns * clk_hz / 1e9), never below one.
  function automatic int unsigned len_cycles(input longint unsigned clk_hz,
                                             input logic [LEN_W-1:0] code);
    longint unsigned prod;
    longint unsigned q;
    prod = longint'(len_ns(code)) * clk_hz;
    q    = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (q == 0) q = 1;
    return int'(q);
  endfunction

endpackage

// File: rtl/wdog_seq.sv
module wdog_seq #(
  parameter int CNT_W = 32
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      en,
  input  logic                                      feed,
  input  logic [wdog_pkg::NSTAGE*CNT_W-1:0]         limits,
  input  logic [wdog_pkg::NSTAGE*wdog_pkg::ACT_W-1:0] acts,
  output logic                                      fire,
  output logic [wdog_pkg::ACT_W-1:0]                fire_act
);
  localparam int SW = $clog2(wdog_pkg::NSTAGE);

  logic [SW-1:0]    stage;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] last;

  assign lim      = limits[stage*CNT_W +: CNT_W];
  assign last     = (lim == '0) ? '0 : lim - 1'b1;
  assign fire     = en && !feed && (cnt == last);
  assign fire_act = acts[stage*wdog_pkg::ACT_W +: wdog_pkg::ACT_W];

  always_ff @(posedge clk) begin
    if (rst || !en || feed) begin
      cnt   <= '0;
      stage <= '0;
    end else if (fire) begin
      cnt   <= '0;
      stage <= stage + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  stage_step_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> (stage == SW'($past(stage) + 1'b1)) && (cnt == '0));
  // R3
  feed_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (en && feed) |=> (stage == '0) && (cnt == '0));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (stage == '0) && (cnt == '0));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter longint unsigned CLK_HZ = 50_000_000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fire,
  input  logic [wdog_pkg::LEN_W-1:0] len_code,
  output logic                       pulse_o
);
  localparam int unsigned MAXC  = wdog_pkg::len_cycles(CLK_HZ, 3'd7);
  localparam int          REM_W = $clog2(MAXC + 1);
  localparam int          NCODE = 1 << wdog_pkg::LEN_W;

  logic [REM_W-1:0] tbl [NCODE];
  logic [REM_W-1:0] rem;

  for (genvar i = 0; i < NCODE; i++) begin : g_tbl
    assign tbl[i] = REM_W'(wdog_pkg::len_cycles(CLK_HZ, wdog_pkg::LEN_W'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem     <= '0;
      pulse_o <= 1'b0;
    end else if (fire) begin
      pulse_o <= 1'b1;
      rem     <= tbl[len_code] - 1'b1;
    end else if (rem != '0) begin
      rem <= rem - 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end

  // R9
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rem != '0) |=> pulse_o);
  // R9
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!fire && rem == '0) |=> !pulse_o);

endmodule

// File: rtl/wdog_stager.sv
module wdog_stager #(
  parameter longint unsigned CLK_HZ     = 50_000_000,
  parameter int              CNT_W      = 32,
  parameter bit              AON_DOMAIN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   feed,
  input  logic                   irq_clr,
  input  logic [4*CNT_W-1:0]     stage_limit_i,
  input  logic [11:0]            stage_act_i,
  input  logic [2:0]             cpu_len_i,
  input  logic [2:0]             sys_len_i,
  output logic                   irq_o,
  output logic                   cpu_rst_o,
  output logic                   sys_rst_o,
  output logic                   aon_rst_o
);
  import wdog_pkg::*;

  localparam int NCH = 3;

  logic             fire;
  logic [ACT_W-1:0] fire_act;
  logic             aon_hit;
  logic [NCH-1:0]   ch_fire;
  logic [LEN_W-1:0] ch_len [NCH];
  logic [NCH-1:0]   ch_out;

  wdog_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .feed     (feed),
    .limits   (stage_limit_i),
    .acts     (stage_act_i),
    .fire     (fire),
    .fire_act (fire_act)
  );

  assign aon_hit    = AON_DOMAIN && (fire_act == ACT_AON);
  assign ch_fire[0] = fire && (fire_act == ACT_CPU);
  assign ch_fire[1] = fire && ((fire_act == ACT_SYS) || aon_hit);
  assign ch_fire[2] = fire && aon_hit;
  assign ch_len[0]  = cpu_len_i;
  assign ch_len[1]  = sys_len_i;
  assign ch_len[2]  = sys_len_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wdog_pulse #(.CLK_HZ(CLK_HZ)) u_pulse (
      .clk      (clk),
      .rst      (rst),
      .fire     (ch_fire[g]),
      .len_code (ch_len[g]),
      .pulse_o  (ch_out[g])
    );
  end

  assign cpu_rst_o = ch_out[0];
  assign sys_rst_o = ch_out[1];
  assign aon_rst_o = ch_out[2];

  always_ff @(posedge clk) begin
    if (rst || !en)                        irq_o <= 1'b0;
    else if (fire && fire_act == ACT_IRQ)  irq_o <= 1'b1;
    else if (irq_clr)                      irq_o <= 1'b0;
  end

  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && fire_act == ACT_IRQ) |=> irq_o);
  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_o);
  // R7
  aon_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aon_rst_o) |-> $past(fire && fire_act == ACT_AON));
  // R8
  aon_variant_chk: assert property (@(posedge clk) disable iff (rst)
    !AON_DOMAIN |-> !aon_rst_o);

endmodule

// File: tb/tb_wdog_stager.sv
module tb_wdog_stager;
  localparam longint unsigned HZ = 50_000_000;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, feed = 1'b0, clr = 1'b0;
  logic [4*CW-1:0] lim = '0;
  logic [11:0] act = '0;
  logic [2:0] clen = '0, slen = '0;
  logic [1:0] irq, cpu, sys, aon;

  int errors = 0;
  int checks = 0;
  string cur = "R1";
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  wdog_stager #(.CLK_HZ(HZ), .CNT_W(CW), .AON_DOMAIN(1'b1)) dut (
    .clk(clk), .rst(rst), .en(en), .feed(feed), .irq_clr(clr),
    .stage_limit_i(lim), .stage_act_i(act), .cpu_len_i(clen), .sys_len_i(slen),
    .irq_o(irq[0]), .cpu_rst_o(cpu[0]), .sys_rst_o(sys[0]), .aon_rst_o(aon[0]));

  wdog_stager #(.CLK_HZ(HZ), .CNT_W(CW), .AON_DOMAIN(1'b0)) dut_plain (
    .clk(clk), .rst(rst), .en(en), .feed(feed), .irq_clr(clr),
    .stage_limit_i(lim), .stage_act_i(act), .cpu_len_i(clen), .sys_len_i(slen),
    .irq_o(irq[1]), .cpu_rst_o(cpu[1]), .sys_rst_o(sys[1]), .aon_rst_o(aon[1]));

  function automatic int exp_cycles(input logic [2:0] c);
    int ns;
    longint unsigned q;
    case (c)
      3'd0: ns = 100;  3'd1: ns = 200;  3'd2: ns = 300;  3'd3: ns = 400;
      3'd4: ns = 500;  3'd5: ns = 800;  3'd6: ns = 1600; default: ns = 3200;
    endcase
    q = (longint'(ns) * HZ + 64'd999_999_999) / 64'd1_000_000_000;
    return (q == 0) ? 1 : int'(q);
  endfunction

  // Reference model, advanced on every rising edge.
  int m_cnt = 0, m_stg = 0;
  int m_irq [2] = '{0, 0};
  int m_cpu [2] = '{0, 0};
  int m_sys [2] = '{0, 0};
  int m_aon [2] = '{0, 0};

  always @(posedge clk) begin
    int l, a;
    bit ex;
    l  = int'(lim[m_stg*CW +: CW]);
    if (l == 0) l = 1;
    a  = int'(act[m_stg*3 +: 3]);
    ex = !rst && en && !feed && (m_cnt == l - 1);
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        m_irq[i] = 0; m_cpu[i] = 0; m_sys[i] = 0; m_aon[i] = 0;
      end else begin
        if (m_cpu[i] > 0) m_cpu[i]--;
        if (m_sys[i] > 0) m_sys[i]--;
        if (m_aon[i] > 0) m_aon[i]--;
        if (!en) m_irq[i] = 0;
        else if (ex && a == 1) m_irq[i] = 1;
        else if (clr) m_irq[i] = 0;
        if (ex && a == 2) m_cpu[i] = exp_cycles(clen);
        if (ex && (a == 3 || (a == 4 && i == 0))) m_sys[i] = exp_cycles(slen);
        if (ex && a == 4 && i == 0) m_aon[i] = exp_cycles(slen);
      end
    end
    if (rst || !en || feed) begin m_cnt = 0; m_stg = 0; end
    else if (ex) begin m_cnt = 0; m_stg = (m_stg + 1) % 4; end
    else m_cnt++;
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < 2; i++) begin
        chk(cur, (i == 0) ? "irq aon-variant" : "irq plain", int'(irq[i]), m_irq[i]);
        chk(cur, "cpu_rst", int'(cpu[i]), (m_cpu[i] > 0) ? 1 : 0);
        chk(cur, "sys_rst", int'(sys[i]), (m_sys[i] > 0) ? 1 : 0);
        chk(cur, "aon_rst", int'(aon[i]), (m_aon[i] > 0) ? 1 : 0);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int l0, l1, l2, l3, input logic [11:0] a);
    lim = {CW'(l3), CW'(l2), CW'(l1), CW'(l0)};
    act = a;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi;
    void'($urandom(32'd1234));
    cyc(3);
    // R1: reset state
    chk("R1", "irq in reset", int'(irq[0]), 0);
    chk("R1", "sys in reset", int'(sys[0]), 0);
    rst = 1'b0;
    cyc(1);
    chk("R1", "all outputs after reset", int'({irq, cpu, sys, aon}), 0);
    cmp_on = 1'b1;

    // R2: stage timing, all irq, with a limit of zero in stage 2
    cur = "R2";
    setup(3, 5, 0, 4, {3'd1, 3'd1, 3'd1, 3'd1});
    en = 1'b1;
    cyc(2);
    chk("R2", "irq before stage 0 limit", int'(irq[0]), 0);
    cyc(1);
    chk("R2", "irq at stage 0 limit", int'(irq[0]), 1);
    // R5: clear, then the next expiry sets it again
    cur = "R5";
    clr = 1'b1; cyc(1); clr = 1'b0;
    chk("R5", "irq cleared", int'(irq[0]), 0);
    cyc(40);
    en = 1'b0; cyc(2);

    // R4: inert codes still advance; only stage 3 raises irq
    cur = "R4";
    setup(2, 2, 2, 2, {3'd1, 3'd7, 3'd6, 3'd5});
    en = 1'b1; cyc(7);
    chk("R4", "irq after stage 2", int'(irq[0]), 0);
    cyc(1);
    chk("R4", "irq after stage 3", int'(irq[0]), 1);
    act = {3'd0, 3'd0, 3'd0, 3'd0}; cyc(20);
    en = 1'b0; cyc(2);

    // R3: feed on the expiring edge blocks the action
    cur = "R3";
    setup(4, 100, 100, 100, {3'd0, 3'd0, 3'd0, 3'd1});
    en = 1'b1; cyc(3);
    feed = 1'b1; cyc(1); feed = 1'b0;
    chk("R3", "irq after fed expiry", int'(irq[0]), 0);
    cyc(3);
    chk("R3", "irq before restarted limit", int'(irq[0]), 0);
    cyc(1);
    chk("R3", "irq after restarted limit", int'(irq[0]), 1);
    en = 1'b0; cyc(2);

    // R6 and R9: every CPU length code
    for (int c = 0; c < 8; c++) begin
      cur = "R6";
      setup(2, 1000, 1000, 1000, {3'd0, 3'd0, 3'd0, 3'd2});
      clen = 3'(c);
      en = 1'b1; hi = 0;
      for (int k = 0; k < 200; k++) begin cyc(1); if (cpu[0]) hi++; end
      chk("R9", $sformatf("cpu width code %0d", c), hi, exp_cycles(3'(c)));
      en = 1'b0; cyc(2);
    end

    // R7: system reset leaves the always-on line low
    cur = "R7";
    setup(2, 1000, 1000, 1000, {3'd0, 3'd0, 3'd0, 3'd3});
    slen = 3'd2; en = 1'b1; cyc(3);
    chk("R7", "sys high", int'(sys[0]), 1);
    chk("R7", "aon low", int'(aon[0]), 0);
    cyc(30); en = 1'b0; cyc(2);

    // R8: code 4 on both variants
    cur = "R8";
    setup(2, 1000, 1000, 1000, {3'd0, 3'd0, 3'd0, 3'd4});
    slen = 3'd1; en = 1'b1; cyc(3);
    chk("R8", "aon variant aon", int'(aon[0]), 1);
    chk("R8", "plain variant sys", int'(sys[1]), 0);
    chk("R8", "plain variant aon", int'(aon[1]), 0);
    cyc(30); en = 1'b0; cyc(2);

    // R10: dropping enable mid-pulse lets the pulse finish
    cur = "R10";
    setup(2, 1000, 1000, 1000, {3'd0, 3'd0, 3'd0, 3'd3});
    slen = 3'd7; en = 1'b1; hi = 0;
    for (int k = 0; k < 12; k++) begin cyc(1); if (sys[0]) hi++; end
    en = 1'b0;
    for (int k = 0; k < 200; k++) begin cyc(1); if (sys[0]) hi++; end
    chk("R10", "sys width across disable", hi, exp_cycles(3'd7));

    // Random mix
    cur = "R2";
    en = 1'b1;
    for (int k = 0; k < 4000; k++) begin
      if (k % 250 == 0) begin
        setup($urandom_range(0, 9), $urandom_range(0, 9), $urandom_range(0, 9),
              $urandom_range(0, 9), 12'($urandom));
        clen = 3'($urandom); slen = 3'($urandom);
      end
      feed = ($urandom_range(0, 99) < 3);
      clr  = ($urandom_range(0, 99) < 10);
      if ($urandom_range(0, 99) < 2) en = ~en;
      cyc(1);
    end
    feed = 1'b0; clr = 1'b0; en = 1'b0;
    cyc(200);
    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule